// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block carries out the processor-side bookkeeping when a trap is taken on a core that nests traps and counts its depth with a trap-level register. A one-cycle trap request comes with an 8-bit trap type. On that clock edge the unit packs the condition codes, the address-space identifier, the 12-bit processor state and the window pointer into a single 40-bit state word. It writes that word, the interrupted PC, the next-PC and the trap type into a per-level stack entry chosen by the trap level as it stood before the trap. It then raises the trap level by one and sends PC and next-PC to the trap vector.

The vector takes the upper bits of the trap base from the core. The trap type goes in at bit 4, and bit 14 marks a trap taken while already inside a trap. Two error conditions refuse the trap and save nothing: interrupts masked in the processor state, and a stack that is already full. A combinational read port lets the rest of the core look at any stack level.

Top module: `trap_entry_unit`

## Requirements
- R1: While rst_n is low and after its release, tl_o is 0, pc_o and npc_o are 0, and done_o, err_masked_o and err_ovf_o are low.
- R2: An accepted trap writes the stack entry at the pre-trap level with the state word: ccr_i at bits 39:32, asi_i at 31:24, zeros at 23:20, pstate_i at 19:8, cwp_i zero-extended into 7:0.
- R3: The same entry stores pc_i, npc_i and trap_type. Setting rd_lvl to a level below MAX_TL shows that entry on the rd_* outputs. Any other rd_lvl reads all zeros.
- R4: An accepted trap raises tl_o by exactly one on the edge that samples trap_req, and done_o is high for the one cycle that follows.
- R5: After an accepted trap, pc_o = {tba_i, nested bit at 14, 2'b00 at 13:12, trap_type at 11:4, 4'b0000}, and npc_o = pc_o + 4.
- R6: Bit 14 of pc_o is 1 exactly when tl_o was above zero before the trap.
- R7: A request with pstate_i[1] (the interrupt-enable bit) at 0 pulses err_masked_o for one cycle. It leaves tl_o, pc_o, npc_o and every stack entry unchanged and does not raise done_o.
- R8: A request with tl_o equal to MAX_TL (default 5) pulses err_ovf_o for one cycle and saves nothing. tl_o never exceeds MAX_TL.
- R9: Without a request, tl_o, pc_o and npc_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_type | input | TT_W (8) | Trap type code |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| pstate_i | input | 12 | Current processor state; bit 1 is interrupt enable |
| cwp_i | input | CWP_W (5) | Current window pointer |
| pc_i | input | AW (64) | PC of the trapped instruction |
| npc_i | input | AW (64) | Next-PC of the trapped instruction |
| tba_i | input | AW-15 | Trap base address bits AW-1:15 |
| rd_lvl | input | TL_W (3) | Stack level to read |
| tl_o | output | TL_W (3) | Current trap level |
| pc_o | output | AW | Redirected PC |
| npc_o | output | AW | Redirected next-PC |
| done_o | output | 1 | One-cycle strobe after an accepted trap |
| err_masked_o | output | 1 | Trap refused, interrupts masked |
| err_ovf_o | output | 1 | Trap refused, stack full |
| rd_tstate_o | output | 40 | Saved state word at rd_lvl |
| rd_tpc_o | output | AW | Saved PC at rd_lvl |
| rd_tnpc_o | output | AW | Saved next-PC at rd_lvl |
| rd_tt_o | output | TT_W | Saved trap type at rd_lvl |

## Verification
The hardest case to reach is the full stack. No trap can be refused for overflow until five accepted traps have filled every level, and only then does the sixth request show whether the level register saturates and the top entry stays intact. The stimulus issues a chain of nested traps with distinct data at each level, fires one more at the limit, and then reads every level back. A second reset then shows that a masked trap leaves entry 0 holding its data from before the reset.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TSTATE_W = 40;
  localparam int IE_BIT   = 1;
  localparam int NEST_BIT = 14;
  localparam int TT_LSB   = 4;

  typedef struct packed {
    logic [7:0]  ccr;
    logic [7:0]  asi;
    logic [3:0]  rsvd;
    logic [11:0] pst;
    logic [7:0]  cwp;
  } tstate_t;

  function automatic tstate_t pack_tstate(input logic [7:0] ccr,
                                          input logic [7:0] asi,
                                          input logic [11:0] pst,
                                          input logic [7:0] cwp);
    tstate_t t;
    t.ccr  = ccr;
    t.asi  = asi;
    t.rsvd = 4'h0;
    t.pst  = pst;
    t.cwp  = cwp;
    return t;
  endfunction

endpackage

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl #(
  parameter int MAX_TL = 5,
  parameter int TL_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic            ie,
  output logic [TL_W-1:0] tl_q,
  output logic            save_en,
  output logic            nested,
  output logic            done_q,
  output logic            err_masked_q,
  output logic            err_ovf_q
);

  localparam logic [TL_W-1:0] MAX_V = TL_W'(MAX_TL);

  logic [TL_W-1:0] tl_d;
  logic            at_max;
  logic            done_d, errm_d, erro_d;

  always_comb begin
    at_max  = (tl_q == MAX_V);
    save_en = trap_req & ie & ~at_max;
    nested  = (tl_q != '0);
    tl_d    = tl_q;
    if (save_en) tl_d = tl_q + 1'b1;
    done_d  = save_en;
    errm_d  = trap_req & ~ie;
    erro_d  = trap_req & at_max;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q         <= '0;
      done_q       <= 1'b0;
      err_masked_q <= 1'b0;
      err_ovf_q    <= 1'b0;
    end else begin
      tl_q         <= tl_d;
      done_q       <= done_d;
      err_masked_q <= errm_d;
      err_ovf_q    <= erro_d;
    end
  end

  AST_TL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (tl_q == $past(tl_q) + 1'b1) && done_q); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q <= MAX_V); // R8
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ie) |=> $stable(tl_q) && err_masked_q && !done_q); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(tl_q) && !done_q); // R9

endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int DEPTH = 5,
  parameter int TL_W  = 3,
  parameter int AW    = 64,
  parameter int TT_W  = 8
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [TL_W-1:0]                     wr_lvl,
  input  trap_entry_pkg::tstate_t             wr_ts,
  input  logic [AW-1:0]                       wr_pc,
  input  logic [AW-1:0]                       wr_npc,
  input  logic [TT_W-1:0]                     wr_tt,
  input  logic [TL_W-1:0]                     rd_lvl,
  output logic [trap_entry_pkg::TSTATE_W-1:0] rd_ts,
  output logic [AW-1:0]                       rd_pc,
  output logic [AW-1:0]                       rd_npc,
  output logic [TT_W-1:0]                     rd_tt
);

  trap_entry_pkg::tstate_t ts_mem  [DEPTH];
  logic [AW-1:0]           pc_mem  [DEPTH];
  logic [AW-1:0]           npc_mem [DEPTH];
  logic [TT_W-1:0]         tt_mem  [DEPTH];
  logic [DEPTH-1:0]        sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    assign sel[g] = wr_en && (wr_lvl == TL_W'(g));
    always_ff @(posedge clk) begin
      if (sel[g]) begin
        ts_mem[g]  <= wr_ts;
        pc_mem[g]  <= wr_pc;
        npc_mem[g] <= wr_npc;
        tt_mem[g]  <= wr_tt;
      end
    end
  end

  always_comb begin
    rd_ts  = '0;
    rd_pc  = '0;
    rd_npc = '0;
    rd_tt  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_lvl == TL_W'(i)) begin
        rd_ts  = ts_mem[i];
        rd_pc  = pc_mem[i];
        rd_npc = npc_mem[i];
        rd_tt  = tt_mem[i];
      end
    end
  end

  always_comb begin
    AST_ONE_ENTRY: assert ($onehot0(sel)); // R2
  end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
  parameter int AW   = 64,
  parameter int TT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-16:0]  tba,
  input  logic            nested,
  input  logic [TT_W-1:0] tt,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   npc_q
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] vec;
  logic [AW-1:0] pc_d, npc_d;

  always_comb begin
    vec = '0;
    vec[AW-1:15] = tba;
    vec[trap_entry_pkg::NEST_BIT] = nested;
    vec[trap_entry_pkg::TT_LSB +: TT_W] = tt;
    pc_d  = pc_q;
    npc_d = npc_q;
    if (load) begin
      pc_d  = vec;
      npc_d = vec + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      npc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      npc_q <= npc_d;
    end
  end

  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (npc_q == pc_q + STEP) && (pc_q[3:0] == 4'h0)); // R5

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int AW     = 64,
  parameter int TT_W   = 8,
  parameter int CWP_W  = 5,
  parameter int MAX_TL = 5,
  parameter int TL_W   = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                trap_req,
  input  logic [TT_W-1:0]                     trap_type,
  input  logic [7:0]                          ccr_i,
  input  logic [7:0]                          asi_i,
  input  logic [11:0]                         pstate_i,
  input  logic [CWP_W-1:0]                    cwp_i,
  input  logic [AW-1:0]                       pc_i,
  input  logic [AW-1:0]                       npc_i,
  input  logic [AW-16:0]                      tba_i,
  input  logic [TL_W-1:0]                     rd_lvl,
  output logic [TL_W-1:0]                     tl_o,
  output logic [AW-1:0]                       pc_o,
  output logic [AW-1:0]                       npc_o,
  output logic                                done_o,
  output logic                                err_masked_o,
  output logic                                err_ovf_o,
  output logic [trap_entry_pkg::TSTATE_W-1:0] rd_tstate_o,
  output logic [AW-1:0]                       rd_tpc_o,
  output logic [AW-1:0]                       rd_tnpc_o,
  output logic [TT_W-1:0]                     rd_tt_o
);

  logic                    save_en;
  logic                    nested;
  logic [7:0]              cwp_ext;
  trap_entry_pkg::tstate_t ts_word;

  always_comb begin
    cwp_ext = '0;
    cwp_ext[CWP_W-1:0] = cwp_i;
    ts_word = trap_entry_pkg::pack_tstate(ccr_i, asi_i, pstate_i, cwp_ext);
  end

  trap_level_ctrl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req),
    .ie(pstate_i[trap_entry_pkg::IE_BIT]),
    .tl_q(tl_o), .save_en(save_en), .nested(nested),
    .done_q(done_o), .err_masked_q(err_masked_o), .err_ovf_q(err_ovf_o)
  );

  trap_stack #(.DEPTH(MAX_TL), .TL_W(TL_W), .AW(AW), .TT_W(TT_W)) u_stack (
    .clk(clk), .wr_en(save_en), .wr_lvl(tl_o), .wr_ts(ts_word),
    .wr_pc(pc_i), .wr_npc(npc_i), .wr_tt(trap_type), .rd_lvl(rd_lvl),
    .rd_ts(rd_tstate_o), .rd_pc(rd_tpc_o), .rd_npc(rd_tnpc_o), .rd_tt(rd_tt_o)
  );

  trap_vector_gen #(.AW(AW), .TT_W(TT_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .load(save_en), .tba(tba_i),
    .nested(nested), .tt(trap_type), .pc_q(pc_o), .npc_q(npc_o)
  );

  AST_NEST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_o[trap_entry_pkg::NEST_BIT] == (tl_o > TL_W'(1)))); // R6
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_masked_o || err_ovf_o) |-> !done_o); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf_o |-> $stable(pc_o) && (tl_o == TL_W'(MAX_TL))); // R8

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;

  localparam int AW = 64;

  typedef struct {
    int          kind;   // 0 done, 1 masked, 2 overflow
    logic [2:0]  tl;
    logic [63:0] pc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req;
  logic [7:0]  trap_type, ccr_i, asi_i;
  logic [11:0] pstate_i;
  logic [4:0]  cwp_i;
  logic [63:0] pc_i, npc_i;
  logic [48:0] tba_i;
  logic [2:0]  rd_lvl;
  logic [2:0]  tl_o;
  logic [63:0] pc_o, npc_o, rd_tpc_o, rd_tnpc_o;
  logic        done_o, err_masked_o, err_ovf_o;
  logic [39:0] rd_tstate_o;
  logic [7:0]  rd_tt_o;

  int n_chk = 0, n_bad = 0;
  exp_t sb[$];
  logic [2:0]  bm_tl;
  logic [63:0] bm_pc;
  logic [39:0] e_ts  [5];
  logic [63:0] e_pc  [5];
  logic [63:0] e_npc [5];
  logic [7:0]  e_tt  [5];

  always #2.5 clk = ~clk;

  trap_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .ccr_i(ccr_i), .asi_i(asi_i), .pstate_i(pstate_i), .cwp_i(cwp_i),
    .pc_i(pc_i), .npc_i(npc_i), .tba_i(tba_i), .rd_lvl(rd_lvl),
    .tl_o(tl_o), .pc_o(pc_o), .npc_o(npc_o), .done_o(done_o),
    .err_masked_o(err_masked_o), .err_ovf_o(err_ovf_o),
    .rd_tstate_o(rd_tstate_o), .rd_tpc_o(rd_tpc_o), .rd_tnpc_o(rd_tnpc_o),
    .rd_tt_o(rd_tt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard whenever the design reports an outcome
  always @(negedge clk) begin
    if (rst_n && (done_o || err_masked_o || err_ovf_o)) begin
      if (sb.size() == 0) begin
        chk("R4 unexpected outcome", 64'(1), 64'(0));
      end else begin
        exp_t e;
        int   k;
        e = sb.pop_front();
        k = done_o ? 0 : (err_masked_o ? 1 : 2);
        chk((e.kind == 0) ? "R4 outcome kind" : (e.kind == 1) ? "R7 outcome kind" : "R8 outcome kind",
            64'(k), 64'(e.kind));
        chk("R4 R8 R7 trap level", 64'(tl_o), 64'(e.tl));
        chk("R5 R6 pc", pc_o, e.pc);
        chk("R5 npc", npc_o, (e.kind == 0) ? e.pc + 64'd4 : npc_o);
        if (e.kind != 0) chk("R7 R8 one-cycle error", 64'(done_o), 64'(0));
      end
    end
  end

  task automatic trap(input logic [7:0] tt, input logic [7:0] ccr, input logic [7:0] asi,
                      input logic [11:0] pst, input logic [4:0] cwp,
                      input logic [63:0] pc, input logic [63:0] npc);
    exp_t e;
    if (!pst[1]) begin
      e.kind = 1;
    end else if (bm_tl == 3'd5) begin
      e.kind = 2;
    end else begin
      e.kind = 0;
      e_ts[bm_tl]  = {ccr, asi, 4'h0, pst, 3'b000, cwp};
      e_pc[bm_tl]  = pc;
      e_npc[bm_tl] = npc;
      e_tt[bm_tl]  = tt;
      bm_pc = {tba_i, (bm_tl != 3'd0), 2'b00, tt, 4'h0};
      bm_tl = bm_tl + 3'd1;
    end
    e.tl = bm_tl;
    e.pc = bm_pc;
    sb.push_back(e);
    trap_type = tt; ccr_i = ccr; asi_i = asi; pstate_i = pst;
    cwp_i = cwp; pc_i = pc; npc_i = npc; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    @(negedge clk);
    chk("R4 R7 R8 outcome seen", 64'(sb.size()), 64'(0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trap_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 tl in reset", 64'(tl_o), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tl after reset", 64'(tl_o), 64'(0));
    chk("R1 pc after reset", pc_o, 64'(0));
    chk("R1 npc after reset", npc_o, 64'(0));
    chk("R1 strobes low", {61'(0), done_o, err_masked_o, err_ovf_o}, 64'(0));
    bm_tl = 3'd0;
    bm_pc = 64'd0;
  endtask

  task automatic read_lvl(input int lvl);
    rd_lvl = 3'(lvl);
    #1;
    chk("R2 saved state word", 64'(rd_tstate_o), 64'(e_ts[lvl]));
    chk("R3 saved pc", rd_tpc_o, e_pc[lvl]);
    chk("R3 saved npc", rd_tnpc_o, e_npc[lvl]);
    chk("R3 saved trap type", 64'(rd_tt_o), 64'(e_tt[lvl]));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    trap_req = 1'b0; trap_type = '0; ccr_i = '0; asi_i = '0; pstate_i = '0;
    cwp_i = '0; pc_i = '0; npc_i = '0; rd_lvl = '0;
    tba_i = 49'h0_00AB_CDEF_1357;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // five nested traps fill the stack (R2 R3 R4 R5 R6)
    for (int i = 0; i < 5; i++) begin
      trap(8'h10 + 8'(i * 27), 8'hC0 ^ 8'(i), 8'h80 + 8'(i), 12'hA02 | 12'(i << 4),
           5'(i * 7), 64'h4000_0000 + 64'(i * 64'h100), 64'h4000_0004 + 64'(i * 64'h100));
      repeat (i) @(negedge clk);
      chk("R9 idle hold tl", 64'(tl_o), 64'(bm_tl));
      chk("R9 idle hold pc", pc_o, bm_pc);
    end

    // request at the limit (R8)
    trap(8'hEE, 8'h11, 8'h22, 12'hFFF, 5'h1F, 64'hDEAD_0000, 64'hDEAD_0004);
    for (int i = 0; i < 5; i++) read_lvl(i);
    rd_lvl = 3'd6;
    #1;
    chk("R3 out-of-range read zero", rd_tpc_o | rd_tnpc_o | 64'(rd_tstate_o) | 64'(rd_tt_o), 64'(0));

    // masked trap after reset leaves entry 0 alone (R7)
    do_reset();
    trap(8'h33, 8'h44, 8'h55, 12'hFFD, 5'h03, 64'hBAD0_0000, 64'hBAD0_0004);
    read_lvl(0);

    // fresh trap at level zero: no nesting bit, largest trap type (R5 R6)
    tba_i = 49'h1_FFFF_FFFF_FFFF;
    trap(8'hFF, 8'h01, 8'h02, 12'h003, 5'h1F, 64'h8000_0000, 64'h8000_0004);
    read_lvl(0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule